// File: doc/BRIEF.md
# UART register front end with interrupt priority

This block is the bus-facing half of a 16550-style serial port without FIFOs. A host reaches eight 32-bit word registers through a simple select/write-enable port. Behind the registers sits a serializer core. This block receives a byte from that core through a valid strobe and holds it in a single-byte receive register. It hands each byte the host writes to the core through a one-cycle transmit strobe. It also keeps the line and modem status that the host polls. The control values the core needs are driven straight out of the block: interrupt enables, line control, modem control and the baud divisor.

One level-sensitive interrupt line is driven from a four-level priority encoder. The identification code of the highest pending source can be read back. Receive error events and modem-status bits arrive as inputs from the serializer and the modem pin sampler. This block only latches and prioritises them.

Stream rules: `tx_valid` is a one-cycle beat with no back-pressure, and the core must accept it. `rx_ready` advertises that the holding register is empty. It is advisory only. A beat on `rx_valid` while `rx_ready` is low is still taken: the byte replaces the held byte and raises overrun.

Top module: `uart_regfile_irq`

## Requirements
- R1: The register is selected by byte address bits [4:2], and bits [1:0] are ignored. The word indices are: 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor.
- R2: After reset, line status reads 0x60. Identification reads 0x01. All other registers read 0. `irq` is low, `rx_ready` is high and `tx_valid` is low.
- R3: A beat on `rx_valid` stores `rx_data` and sets data-ready (line status bit 0). `rx_ready` equals the inverse of data-ready.
- R4: A read of index 0 returns the held byte, zero-extended, and clears data-ready at the clock edge. If a byte arrives on the same edge, data-ready stays set and no overrun is raised.
- R5: A byte that arrives while data-ready is set, with no data read on that edge, sets overrun (bit 1). Data-ready stays set and the new byte replaces the held one.
- R6: Error inputs present with a received byte set sticky flags: parity to bit 2, framing to bit 3, break to bit 4. A read of index 5 returns the current value and clears bits 1 to 4 on that edge. A new event on the same edge wins over the clear. Bits 5 and 6 always read 1.
- R7: A write of index 0 makes `tx_valid` high for exactly the following cycle, with `tx_data` equal to write-data bits [7:0].
- R8: Indices 1, 3, 4 and 7 are write-only and read as 0. Each one drives its own output: enable bits [3:0] on `int_enable`, line control [7:0] on `line_ctrl`, modem control [1:0] on `modem_ctrl`, divisor [DIV_W-1:0] on `divisor`.
- R9: Writes to indices 2, 5 and 6 change no state.
- R10: Modem status (index 6) holds `{modem_level, modem_delta}` as registered one cycle earlier.
- R11: The identification code follows this priority. Any of line-status bits 1 to 4 with enable bit 2 gives 3'b110. Data-ready with enable bit 0 gives 3'b100. Transmit-empty with enable bit 1 gives 3'b010. Any modem-status bit [3:0] with enable bit 3 gives 3'b000. Otherwise the code is 3'b001. Index 2 reads the code in bits [2:0].
- R12: `irq` is high exactly when the code is not 3'b001. It is derived only from registered state, so it never rises while all enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte beat |
| tx_data | output | BYTE_W | Transmit byte |
| rx_valid | input | 1 | Receive byte beat |
| rx_data | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Holding register empty |
| rx_par_err | input | 1 | Parity error with this byte |
| rx_frm_err | input | 1 | Framing error with this byte |
| rx_brk_err | input | 1 | Break seen with this byte |
| modem_delta | input | 4 | Modem change flags |
| modem_level | input | 4 | Modem line levels |
| int_enable | output | 4 | Interrupt enable register |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 2 | Modem control register |
| divisor | output | DIV_W | Baud divisor register |
| irq | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the edges where two status updates collide. One is a byte arriving in the same cycle as the host reads the data register. The other is a new error arriving in the same cycle as a line-status read. The bench drives `rx_valid` and the bus access on the same cycle to hit both, then reads the resulting flags back. Priority ordering is covered by a vector table. Each entry combines an enable mask, an optional byte with error flags, and modem change bits, so that several sources are pending at once and the winning code is known.

// File: rtl/uart_rif_pkg.sv
package uart_rif_pkg;

  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned ADDR_W    = REG_IDX_W + 2;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned IEN_W     = 4;
  localparam int unsigned LINE_W    = 8;
  localparam int unsigned MCTL_W    = 2;
  localparam int unsigned MDM_W     = 4;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_DATA  = 3'd0,
    IDX_IEN   = 3'd1,
    IDX_IID   = 3'd2,
    IDX_LINE  = 3'd3,
    IDX_MCTL  = 3'd4,
    IDX_LSTAT = 3'd5,
    IDX_MSTAT = 3'd6,
    IDX_DIV   = 3'd7
  } reg_idx_e;

  // line status bit positions
  localparam int unsigned LS_RDY  = 0;
  localparam int unsigned LS_OVR  = 1;
  localparam int unsigned LS_PAR  = 2;
  localparam int unsigned LS_FRM  = 3;
  localparam int unsigned LS_BRK  = 4;
  localparam int unsigned LS_THE  = 5;
  localparam int unsigned LS_TEM  = 6;

  // interrupt enable bit positions
  localparam int unsigned IE_RXD  = 0;
  localparam int unsigned IE_THE  = 1;
  localparam int unsigned IE_LINE = 2;
  localparam int unsigned IE_MDM  = 3;

  typedef enum logic [2:0] {
    ID_LINE = 3'b110,
    ID_RXD  = 3'b100,
    ID_THE  = 3'b010,
    ID_MDM  = 3'b000,
    ID_NONE = 3'b001
  } irq_id_e;

endpackage

// File: rtl/uart_rif_ctrl.sv
module uart_rif_ctrl
  import uart_rif_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  reg_idx_e          wr_idx_i,
  input  logic [DIV_W-1:0]  wdata_i,
  output logic [IEN_W-1:0]  ien_o,
  output logic [LINE_W-1:0] line_o,
  output logic [MCTL_W-1:0] mctl_o,
  output logic [DIV_W-1:0]  div_o
);

  logic [IEN_W-1:0]  ien_q;
  logic [LINE_W-1:0] line_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [DIV_W-1:0]  div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= '0;
      line_q <= '0;
      mctl_q <= '0;
      div_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_idx_i)
        IDX_IEN:  ien_q  <= wdata_i[IEN_W-1:0];
        IDX_LINE: line_q <= wdata_i[LINE_W-1:0];
        IDX_MCTL: mctl_q <= wdata_i[MCTL_W-1:0];
        IDX_DIV:  div_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign ien_o  = ien_q;
  assign line_o = line_q;
  assign mctl_o = mctl_q;
  assign div_o  = div_q;

  // R8
  ien_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == IDX_IEN) |=> (ien_o == $past(wdata_i[IEN_W-1:0])));

  // R9
  ro_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_idx_i == IDX_IID || wr_idx_i == IDX_LSTAT || wr_idx_i == IDX_MSTAT))
    |=> ($stable(ien_o) && $stable(line_o) && $stable(mctl_o) && $stable(div_o)));

endmodule

// File: rtl/uart_rif_rxstat.sv
module uart_rif_rxstat
  import uart_rif_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              brk_err_i,
  input  logic              rd_data_i,
  input  logic              rd_lstat_i,
  output logic [BYTE_W-1:0] hold_o,
  output logic [STAT_W-1:0] lstat_o
);

  localparam int unsigned NUM_ERR = LS_BRK - LS_OVR + 1;

  logic [BYTE_W-1:0]  hold_q;
  logic               rdy_q;
  logic [NUM_ERR-1:0] err_q;
  logic [NUM_ERR-1:0] err_set;

  // overrun: new byte lands on a pending byte that is not being read now
  assign err_set[LS_OVR-LS_OVR] = rx_valid_i && rdy_q && !rd_data_i;
  assign err_set[LS_PAR-LS_OVR] = rx_valid_i && par_err_i;
  assign err_set[LS_FRM-LS_OVR] = rx_valid_i && frm_err_i;
  assign err_set[LS_BRK-LS_OVR] = rx_valid_i && brk_err_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (rx_valid_i) hold_q <= rx_data_i;
      if (rx_valid_i)     rdy_q <= 1'b1;
      else if (rd_data_i) rdy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    always_ff @(posedge clk) begin
      if (!rst_n)          err_q[g] <= 1'b0;
      else if (err_set[g]) err_q[g] <= 1'b1;
      else if (rd_lstat_i) err_q[g] <= 1'b0;
    end
  end

  assign hold_o  = hold_q;
  assign lstat_o = {1'b0, 1'b1, 1'b1, err_q, rdy_q};

  // R3
  rx_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> lstat_o[LS_RDY]);

  // R4
  rd_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !rx_valid_i) |=> !lstat_o[LS_RDY]);

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && lstat_o[LS_RDY] && !rd_data_i) |=> (lstat_o[LS_OVR] && hold_o == $past(rx_data_i)));

  // R6
  lstat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lstat_i && !rx_valid_i) |=> (lstat_o[LS_BRK:LS_OVR] == '0));

endmodule

// File: rtl/uart_rif_irq.sv
module uart_rif_irq
  import uart_rif_pkg::*;
(
  input  logic [STAT_W-1:0] lstat_i,
  input  logic [STAT_W-1:0] mstat_i,
  input  logic [IEN_W-1:0]  ien_i,
  output irq_id_e           id_o,
  output logic              irq_o
);

  logic p_line, p_rxd, p_the, p_mdm;
  logic unused_bits;

  assign p_line = (|lstat_i[LS_BRK:LS_OVR]) && ien_i[IE_LINE];
  assign p_rxd  = lstat_i[LS_RDY] && ien_i[IE_RXD];
  assign p_the  = lstat_i[LS_THE] && ien_i[IE_THE];
  assign p_mdm  = (|mstat_i[MDM_W-1:0]) && ien_i[IE_MDM];
  assign unused_bits = ^{lstat_i[STAT_W-1:LS_TEM], mstat_i[STAT_W-1:MDM_W]};

  always_comb begin
    if (p_line)     id_o = ID_LINE;
    else if (p_rxd) id_o = ID_RXD;
    else if (p_the) id_o = ID_THE;
    else if (p_mdm) id_o = ID_MDM;
    else            id_o = ID_NONE;
  end

  assign irq_o = p_line | p_rxd | p_the | p_mdm;

endmodule

// File: rtl/uart_regfile_irq.sv
module uart_regfile_irq
  import uart_rif_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk_err,
  input  logic [MDM_W-1:0]  modem_delta,
  input  logic [MDM_W-1:0]  modem_level,
  output logic [IEN_W-1:0]  int_enable,
  output logic [LINE_W-1:0] line_ctrl,
  output logic [MCTL_W-1:0] modem_ctrl,
  output logic [DIV_W-1:0]  divisor,
  output logic              irq
);

  reg_idx_e          idx;
  logic              wr_acc, rd_acc;
  logic              unused_addr_wdata;
  logic [BYTE_W-1:0] hold;
  logic [STAT_W-1:0] lstat;
  logic [STAT_W-1:0] mstat_q;
  logic [IEN_W-1:0]  ien;
  irq_id_e           iid;
  logic              tx_valid_q;
  logic [BYTE_W-1:0] tx_data_q;

  assign idx    = reg_idx_e'(bus_addr[ADDR_W-1:2]);
  assign wr_acc = bus_sel && bus_we;
  assign rd_acc = bus_sel && !bus_we;
  assign unused_addr_wdata = ^{bus_addr[1:0], bus_wdata[DATA_W-1:DIV_W]};

  uart_rif_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_acc),
    .wr_idx_i (idx),
    .wdata_i  (bus_wdata[DIV_W-1:0]),
    .ien_o    (ien),
    .line_o   (line_ctrl),
    .mctl_o   (modem_ctrl),
    .div_o    (divisor)
  );

  uart_rif_rxstat #(.BYTE_W(BYTE_W)) rxstat_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .par_err_i  (rx_par_err),
    .frm_err_i  (rx_frm_err),
    .brk_err_i  (rx_brk_err),
    .rd_data_i  (rd_acc && idx == IDX_DATA),
    .rd_lstat_i (rd_acc && idx == IDX_LSTAT),
    .hold_o     (hold),
    .lstat_o    (lstat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mstat_q <= '0;
    else        mstat_q <= {modem_level, modem_delta};
  end

  uart_rif_irq irq_i (
    .lstat_i (lstat),
    .mstat_i (mstat_q),
    .ien_i   (ien),
    .id_o    (iid),
    .irq_o   (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr_acc && idx == IDX_DATA;
      if (wr_acc && idx == IDX_DATA) tx_data_q <= bus_wdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (idx)
        IDX_DATA:  bus_rdata = {{(DATA_W-BYTE_W){1'b0}}, hold};
        IDX_IID:   bus_rdata = {{(DATA_W-3){1'b0}}, iid};
        IDX_LSTAT: bus_rdata = {{(DATA_W-STAT_W){1'b0}}, lstat};
        IDX_MSTAT: bus_rdata = {{(DATA_W-STAT_W){1'b0}}, mstat_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign tx_valid   = tx_valid_q;
  assign tx_data    = tx_data_q;
  assign rx_ready   = !lstat[LS_RDY];
  assign int_enable = ien;

  // R7
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && idx == IDX_DATA) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

  // R7
  tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_acc && idx == IDX_DATA) |=> !tx_valid);

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_enable == '0) |-> !irq);

  // R11
  line_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lstat[LS_BRK:LS_OVR]) && int_enable[IE_LINE]) |-> (iid == ID_LINE && irq));

  // R10
  mstat_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mstat_q == $past({modem_level, modem_delta})));

endmodule

// File: tb/uart_regfile_irq_tb_top.sv
module uart_regfile_irq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk_err = 1'b0;
  logic [3:0]  modem_delta = '0, modem_level = '0;
  logic [3:0]  int_enable;
  logic [7:0]  line_ctrl;
  logic [1:0]  modem_ctrl;
  logic [15:0] divisor;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  uart_regfile_irq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk_err(rx_brk_err),
    .modem_delta(modem_delta), .modem_level(modem_level),
    .int_enable(int_enable), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
    .divisor(divisor), .irq(irq)
  );

  // vector: [14:11] enables, [10] send byte, [9:7] {break,frame,parity}, [6:3] modem delta, [2:0] expected id
  localparam int NVEC = 12;
  localparam logic [14:0] VEC [NVEC] = '{
    {4'h0, 1'b0, 3'b000, 4'h0, 3'b001},
    {4'h1, 1'b1, 3'b000, 4'h0, 3'b100},
    {4'h2, 1'b0, 3'b000, 4'h0, 3'b010},
    {4'h8, 1'b0, 3'b000, 4'h1, 3'b000},
    {4'h4, 1'b1, 3'b001, 4'h0, 3'b110},
    {4'hF, 1'b1, 3'b010, 4'h4, 3'b110},
    {4'hB, 1'b1, 3'b100, 4'h0, 3'b100},
    {4'hA, 1'b0, 3'b000, 4'h2, 3'b010},
    {4'h8, 1'b0, 3'b000, 4'h0, 3'b001},
    {4'h1, 1'b0, 3'b000, 4'h0, 3'b001},
    {4'h4, 1'b1, 3'b000, 4'h0, 3'b001},
    {4'h9, 1'b0, 3'b000, 4'h8, 3'b000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic [2:0] errs);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    {rx_brk_err, rx_frm_err, rx_par_err} = errs;
    @(negedge clk);
    rx_valid = 1'b0; {rx_brk_err, rx_frm_err, rx_par_err} = 3'b000;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    bus_read(5'h14, rd); check("R2 line status", rd, 32'h60);
    bus_read(5'h08, rd); check("R2 ident", rd, 32'h01);
    bus_read(5'h00, rd); check("R2 data", rd, 32'h00);
    bus_read(5'h18, rd); check("R2 modem status", rd, 32'h00);
    check("R2 irq", {31'b0, irq}, 32'h0);
    check("R2 rx_ready", {31'b0, rx_ready}, 32'h1);
    check("R2 tx_valid", {31'b0, tx_valid}, 32'h0);

    // R1 low address bits ignored: ident at 0x0B
    bus_read(5'h0B, rd); check("R1 ident via 0x0B", rd, 32'h01);

    // R11 R12 priority table
    for (int i = 0; i < NVEC; i++) begin
      bus_write(5'h04, {28'b0, VEC[i][14:11]});
      if (VEC[i][10]) rx_send(8'h40 + 8'(i), VEC[i][9:7]);
      modem_delta = VEC[i][6:3];
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R12 irq vec %0d", i), {31'b0, irq}, {31'b0, VEC[i][2:0] != 3'b001});
      bus_read(5'h08, rd);
      check($sformatf("R11 ident vec %0d", i), rd, {29'b0, VEC[i][2:0]});
      modem_delta = 4'h0;
      bus_read(5'h00, rd);
      bus_read(5'h14, rd);
      bus_write(5'h04, 32'h0);
    end

    // R7 transmit strobe
    bus_write(5'h00, 32'h1A5);
    check("R7 tx_valid high", {31'b0, tx_valid}, 32'h1);
    check("R7 tx_data", {24'b0, tx_data}, 32'hA5);
    @(negedge clk);
    check("R7 tx_valid one cycle", {31'b0, tx_valid}, 32'h0);

    // R8 write-only control registers; R1 via addr 0x0F
    bus_write(5'h0F, 32'h3B);
    check("R8 line_ctrl", {24'b0, line_ctrl}, 32'h3B);
    bus_read(5'h0C, rd); check("R8 line reads zero", rd, 32'h0);
    bus_write(5'h10, 32'h3);
    check("R8 modem_ctrl", {30'b0, modem_ctrl}, 32'h3);
    bus_write(5'h1C, 32'hFFFF1234);
    check("R8 divisor", {16'b0, divisor}, 32'h1234);
    bus_read(5'h1C, rd); check("R8 divisor reads zero", rd, 32'h0);
    bus_write(5'h04, 32'h5);
    check("R8 int_enable", {28'b0, int_enable}, 32'h5);
    bus_read(5'h04, rd); check("R8 enable reads zero", rd, 32'h0);
    bus_write(5'h04, 32'h0);

    // R9 writes to read-only registers
    bus_write(5'h14, 32'h1F);
    bus_write(5'h08, 32'h0);
    bus_write(5'h18, 32'hFF);
    bus_read(5'h14, rd); check("R9 line status kept", rd, 32'h60);
    bus_read(5'h08, rd); check("R9 ident kept", rd, 32'h01);
    bus_read(5'h18, rd); check("R9 modem status kept", rd, 32'h00);
    check("R9 control outputs kept", {line_ctrl, divisor, modem_ctrl}, {8'h3B, 16'h1234, 2'h3});

    // R10 modem status
    modem_level = 4'hA; modem_delta = 4'h5;
    @(negedge clk);
    bus_read(5'h18, rd); check("R10 modem status", rd, 32'hA5);
    modem_level = 4'h0; modem_delta = 4'h0;
    @(negedge clk);

    // R3 R5 overrun
    rx_send(8'h11, 3'b000);
    check("R3 rx_ready low", {31'b0, rx_ready}, 32'h0);
    rx_send(8'h22, 3'b000);
    bus_read(5'h14, rd); check("R5 overrun flagged", rd, 32'h63);
    bus_read(5'h14, rd); check("R6 status read clears", rd, 32'h61);
    bus_read(5'h00, rd); check("R5 newest byte kept", rd, 32'h22);
    check("R4 rx_ready after read", {31'b0, rx_ready}, 32'h1);
    bus_read(5'h14, rd); check("R4 ready cleared", rd, 32'h60);

    // R4 byte arrives in the data-read cycle
    rx_send(8'h33, 3'b000);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h00;
    rx_valid = 1'b1; rx_data = 8'h44;
    #1 rd = bus_rdata;
    check("R4 read returns held", rd, 32'h33);
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
    bus_read(5'h14, rd); check("R4 no overrun on same-cycle read", rd, 32'h61);
    bus_read(5'h00, rd); check("R4 new byte held", rd, 32'h44);

    // R6 new error collides with status-read clear
    rx_send(8'h55, 3'b001);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h14;
    rx_valid = 1'b1; rx_data = 8'h66; rx_frm_err = 1'b1;
    #1 rd = bus_rdata;
    check("R6 parity flag", rd, 32'h65);
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0; rx_frm_err = 1'b0;
    bus_read(5'h14, rd); check("R6 new event wins over clear", rd, 32'h6B);
    bus_read(5'h00, rd); check("R6 byte", rd, 32'h66);
    bus_read(5'h14, rd); check("R6 cleared", rd, 32'h60);

    finish_run();
  end

endmodule